// File: doc/BRIEF.md
# Low-Power State Controller for a Network Interface

This block decides when a network controller sits in its low-power state and drives the enables that the rest of the chip uses to act on that decision. A sleep request can come from a dedicated input pin or from a bit that software sets in a control register. While the request is in force, the block turns the crystal oscillator enable off. It also releases the host data bus to high impedance, forces the serial-EEPROM and boot-ROM interface outputs to their idle levels and turns off the 16-bit cycle acknowledge.

The pin request is masked whenever the raw, unfiltered reset input or the software reset bit is high. This lets the oscillator run during any reset, even before the reset filter has settled. Every other use of reset inside the block takes the filtered reset, which changes level only after the raw input has held steady for a set number of clocks.

On wake-up the oscillator enable returns at once. The bus and interface enables come back only after a settle count, so the clock is stable before the host side is driven again. Interrupts are held off only for a register-initiated sleep. A pin-initiated sleep lets them through.

Top module: `pwrdn_ctrl`

## Requirements
- R1: With `pd_pin` high and both `rst_raw` and `soft_rst` low, `osc_en`, `bus_oe`, `ext_if_en` and `cs16_en` are all 0 in the same cycle, with no clock edge needed.
- R2: With `pd_reg_bit` high, those four outputs are 0 in the same cycle, whatever the levels of `rst_raw`, `soft_rst` and `pd_pin`.
- R3: While `rst_raw` is 1 and `pd_reg_bit` is 0, `osc_en` is 1 even when `pd_pin` is 1.
- R4: While `soft_rst` is 1 and `pd_reg_bit` is 0, `osc_en` is 1 even when `pd_pin` is 1.
- R5: `rst_clean` takes a new level of `rst_raw` at the 4th rising edge that samples that level, if every one of those 4 samples is equal. A pulse sampled on 3 or fewer edges leaves `rst_clean` unchanged. After power-up `rst_clean` is 1.
- R6: When the sleep condition clears, `osc_en` is 1 in the same cycle. `bus_oe`, `ext_if_en` and `cs16_en` stay 0 through 15 rising edges and become 1 at the 16th rising edge that sees the condition clear.
- R7: `irq_out` is 0 while `pd_reg_bit` is 1. Otherwise `irq_out` equals `irq_in`, which includes a pin-initiated sleep.
- R8: When `rst_clean` is 1 at a rising edge and no sleep condition holds, `bus_oe`, `ext_if_en` and `cs16_en` are 1 after that edge, without waiting out the settle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_raw | input | 1 | Unfiltered reset pin, active high |
| soft_rst | input | 1 | Software reset bit from the configuration register |
| pd_pin | input | 1 | External sleep request pin, active high |
| pd_reg_bit | input | 1 | Sleep request bit from the control register |
| irq_in | input | 1 | Interrupt request from the controller core |
| rst_clean | output | 1 | Filtered reset for all other reset uses |
| osc_en | output | 1 | Crystal oscillator enable |
| bus_oe | output | 1 | Host data bus drive enable; 0 means high impedance |
| ext_if_en | output | 1 | EEPROM/ROM interface enable; 0 forces idle levels |
| cs16_en | output | 1 | 16-bit cycle acknowledge enable |
| irq_out | output | 1 | Gated interrupt request |

## Verification
The sleep gating and the interrupt mask are combinational. Their results are due in the same cycle as the stimulus, so the bench expects them at the falling edge right after it drives the input. The filtered reset is due at the 4th rising edge after a level change, and the bus enables are due at the 16th rising edge after wake-up, or at the 5th after a raw reset that interrupts a sleep. Each result is queued against the exact count of rising edges at which it falls due, and it is compared both one edge early and on time, so a result that arrives early or late is caught.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int FILT_LEN_DEF = 4;
  localparam int SETTLE_DEF   = 16;

  typedef struct packed {
    logic bus_oe;
    logic ext_if_en;
    logic cs16_en;
  } io_en_t;
endpackage

// File: rtl/rst_deglitch.sv
module rst_deglitch #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic raw_i,
  output logic clean_o
);
  logic [FILT_LEN-1:0] hist = '1;
  logic                clean_q = 1'b1;
  logic                seen = 1'b0;
  logic [FILT_LEN-1:0] nxt;

  assign nxt = {hist[FILT_LEN-2:0], raw_i};

  always_ff @(posedge clk) begin
    seen <= 1'b1;
    hist <= nxt;
    if (&nxt)
      clean_q <= 1'b1;
    else if (~|nxt)
      clean_q <= 1'b0;
  end

  assign clean_o = clean_q;

  assert_filter_level_R5: assert property (@(posedge clk) disable iff (!seen)
    (clean_q != $past(clean_q)) |-> ($past(raw_i) == clean_q));
endmodule

// File: rtl/pd_request.sv
module pd_request (
  input  logic pin_i,
  input  logic raw_rst_i,
  input  logic srst_i,
  input  logic reg_bit_i,
  input  logic irq_i,
  output logic pd_eff_o,
  output logic irq_o
);
  logic pin_gated;

  always_comb begin
    pin_gated = pin_i & ~raw_rst_i & ~srst_i;
    pd_eff_o  = pin_gated | reg_bit_i;
    irq_o     = irq_i & ~reg_bit_i;
  end
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
  import pd_pkg::*;
#(
  parameter int SETTLE = 16
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   pd_eff_i,
  output logic   osc_en_o,
  output io_en_t en_o
);
  localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  logic          active_q = 1'b1;
  logic [CW-1:0] cnt_q = '0;
  logic          seen = 1'b0;

  always_ff @(posedge clk) begin
    seen <= 1'b1;
    if (rst) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (pd_eff_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      if (cnt_q == LAST) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    osc_en_o       = ~pd_eff_i;
    en_o.bus_oe    = active_q & ~pd_eff_i;
    en_o.ext_if_en = active_q & ~pd_eff_i;
    en_o.cs16_en   = active_q & ~pd_eff_i;
  end

  assert_settle_done_R6: assert property (@(posedge clk) disable iff (!seen || rst)
    $rose(active_q) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pd_pkg::*;
#(
  parameter int FILT_LEN = FILT_LEN_DEF,
  parameter int SETTLE   = SETTLE_DEF
) (
  input  logic clk,
  input  logic rst_raw,
  input  logic soft_rst,
  input  logic pd_pin,
  input  logic pd_reg_bit,
  input  logic irq_in,
  output logic rst_clean,
  output logic osc_en,
  output logic bus_oe,
  output logic ext_if_en,
  output logic cs16_en,
  output logic irq_out
);
  logic   pd_eff;
  io_en_t en;
  logic   seen = 1'b0;

  rst_deglitch #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk     (clk),
    .raw_i   (rst_raw),
    .clean_o (rst_clean)
  );

  pd_request u_req (
    .pin_i     (pd_pin),
    .raw_rst_i (rst_raw),
    .srst_i    (soft_rst),
    .reg_bit_i (pd_reg_bit),
    .irq_i     (irq_in),
    .pd_eff_o  (pd_eff),
    .irq_o     (irq_out)
  );

  pd_sequencer #(.SETTLE(SETTLE)) u_seq (
    .clk      (clk),
    .rst      (rst_clean),
    .pd_eff_i (pd_eff),
    .osc_en_o (osc_en),
    .en_o     (en)
  );

  assign bus_oe    = en.bus_oe;
  assign ext_if_en = en.ext_if_en;
  assign cs16_en   = en.cs16_en;

  always_ff @(posedge clk) seen <= 1'b1;

  assert_pin_sleep_R1: assert property (@(posedge clk) disable iff (!seen)
    (pd_pin && !rst_raw && !soft_rst) |-> (!osc_en && !bus_oe && !ext_if_en && !cs16_en));
  assert_reg_sleep_R2: assert property (@(posedge clk) disable iff (!seen)
    pd_reg_bit |-> (!osc_en && !bus_oe && !ext_if_en && !cs16_en));
  assert_raw_gate_R3: assert property (@(posedge clk) disable iff (!seen)
    (rst_raw && !pd_reg_bit) |-> osc_en);
  assert_soft_gate_R4: assert property (@(posedge clk) disable iff (!seen)
    (soft_rst && !pd_reg_bit) |-> osc_en);
  assert_osc_first_R6: assert property (@(posedge clk) disable iff (!seen || rst_clean)
    $rose(bus_oe) |-> $past(osc_en));
  assert_irq_mask_R7: assert property (@(posedge clk) disable iff (!seen)
    pd_reg_bit |-> !irq_out);
  assert_irq_pass_R7: assert property (@(posedge clk) disable iff (!seen)
    (!pd_reg_bit && irq_in) |-> irq_out);
  assert_reset_wake_R8: assert property (@(posedge clk) disable iff (!seen)
    ($past(rst_clean) && osc_en && !pd_reg_bit) |-> (bus_oe && ext_if_en && cs16_en));
endmodule

// File: tb/sim_pwrdn_ctrl.sv
module sim_pwrdn_ctrl;
  logic clk = 1'b0;
  logic rst_raw = 1'b1, soft_rst = 1'b0, pd_pin = 1'b0, pd_reg_bit = 1'b0, irq_in = 1'b0;
  logic rst_clean, osc_en, bus_oe, ext_if_en, cs16_en, irq_out;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int       at;
    logic [5:0] mask;
    logic [5:0] val;
    string    req;
  } exp_t;
  exp_t q[$];

  // vector bits: 5 rst_clean, 4 osc_en, 3 bus_oe, 2 ext_if_en, 1 cs16_en, 0 irq_out
  localparam logic [5:0] M_RC = 6'b100000;
  localparam logic [5:0] M_OS = 6'b010000;
  localparam logic [5:0] M_IO = 6'b001110;
  localparam logic [5:0] M_IQ = 6'b000001;

  pwrdn_ctrl u0 (
    .clk(clk), .rst_raw(rst_raw), .soft_rst(soft_rst), .pd_pin(pd_pin),
    .pd_reg_bit(pd_reg_bit), .irq_in(irq_in), .rst_clean(rst_clean),
    .osc_en(osc_en), .bus_oe(bus_oe), .ext_if_en(ext_if_en),
    .cs16_en(cs16_en), .irq_out(irq_out)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic expect_at(input int d, input logic [5:0] m, input logic [5:0] v, input string r);
    exp_t e;
    e.at = cyc + d; e.mask = m; e.val = v; e.req = r;
    q.push_back(e);
  endtask

  // monitor: compares due items at the falling edge
  always @(negedge clk) begin
    logic [5:0] act;
    act = {rst_clean, osc_en, bus_oe, ext_if_en, cs16_en, irq_out};
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.at != cyc) begin
        errors++;
        $display("FAIL %s: check missed, due %0d now %0d", e.req, e.at, cyc);
      end else if ((act & e.mask) != (e.val & e.mask)) begin
        errors++;
        $display("FAIL %s: cycle %0d actual %b expected %b (mask %b)",
                 e.req, cyc, act & e.mask, e.val & e.mask, e.mask);
      end
    end
  end

  initial begin
    // reset state, R8 and R5 power-up value
    step(6);
    expect_at(0, M_RC | M_OS | M_IO | M_IQ, 6'b111110, "R8");
    step(1);

    // R5: filtered reset falls at the 4th edge
    rst_raw = 1'b0;
    expect_at(3, M_RC, 6'b100000, "R5");
    expect_at(4, M_RC, 6'b000000, "R5");
    step(6);

    // R5: 3-edge glitch is ignored
    rst_raw = 1'b1;
    expect_at(3, M_RC, 6'b000000, "R5");
    expect_at(5, M_RC, 6'b000000, "R5");
    step(3);
    rst_raw = 1'b0;
    step(4);

    // R1 and R7: pin sleep, interrupts pass
    irq_in = 1'b1;
    pd_pin = 1'b1;
    expect_at(0, M_OS | M_IO | M_IQ, 6'b000001, "R1");
    step(3);
    // R6: wake-up sequence
    pd_pin = 1'b0;
    expect_at(0, M_OS | M_IO, 6'b010000, "R6");
    expect_at(15, M_IO, 6'b000000, "R6");
    expect_at(16, M_OS | M_IO, 6'b011110, "R6");
    step(18);

    // R2 and R7: register sleep masks interrupts
    pd_reg_bit = 1'b1;
    expect_at(0, M_OS | M_IO | M_IQ, 6'b000000, "R2");
    step(2);
    soft_rst = 1'b1;
    expect_at(0, M_OS | M_IO | M_IQ, 6'b000000, "R2");
    step(2);
    soft_rst = 1'b0;
    pd_reg_bit = 1'b0;
    expect_at(0, M_IQ, 6'b000001, "R7");
    step(20);

    // R4: soft reset masks the pin
    soft_rst = 1'b1;
    pd_pin = 1'b1;
    expect_at(0, M_OS | M_IO, 6'b011110, "R4");
    expect_at(2, M_OS | M_IO, 6'b011110, "R4");
    step(3);
    soft_rst = 1'b0;
    expect_at(0, M_OS | M_IO, 6'b000000, "R4");
    step(2);
    pd_pin = 1'b0;
    step(20);

    // R3 and R8: raw reset masks the pin and wakes the bus early
    pd_pin = 1'b1;
    step(3);
    rst_raw = 1'b1;
    expect_at(0, M_OS | M_IO, 6'b010000, "R3");
    expect_at(4, M_RC | M_IO, 6'b100000, "R8");
    expect_at(5, M_RC | M_OS | M_IO, 6'b111110, "R8");
    step(8);
    rst_raw = 1'b0;
    expect_at(0, M_OS | M_IO, 6'b000000, "R1");
    step(6);
    pd_pin = 1'b0;
    step(20);

    if (q.size() != 0) begin
      errors++;
      $display("FAIL queue: %0d expected items never checked, expected 0", q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule